// File: doc/BRIEF.md
# Floppy Read/Write Bit Sequencer

This block is the small microcoded engine at the heart of a floppy disk controller. It keeps a 4-bit sequence state and an 8-bit data register. On every enabled tick (nominally 2 MHz, so 0.5 µs per tick) it looks up a byte in a 256-entry table. The table address is formed from four mode bits and the current state.

Each table byte supplies two things: the state for the next tick, and an action to apply to the data register. The action can clear the register, shift it left with a 0 or a 1, shift it right while pulling in the write-protect level, or load it in parallel from a register the host has written. When reading, the sequence assembles disk bytes from read pulses. When writing, it serialises the data register onto the head. When sensing, it shifts the write-protect level in.

A bit-timing generator outside the block supplies the tick enable and the read pulse. Host decode outside the block supplies the write and load mode levels and the write register. A tick enable that stays low, as it does while the motor is off, freezes the sequencer.

Top module: `flux_sequencer`

## Requirements
- R1: A low `rst_n` sampled at a clock edge sets the sequence state to 0, the data register to 0x00, and both `head_bit` and `head_strobe` to 0.
- R2: In a clock cycle without `tick_en`, the state and the data register keep their values and `head_strobe` is 0, whatever the other inputs do.
- R3: With `wr_mode`=0 and `ld_mode`=1, every tick replaces the data register with {`wp_level`, data[7:1]} and sends the state to 0.
- R4: The table address is {`wr_mode` (bit 3), `ld_mode` (bit 2), data[7] (bit 1), `rd_pulse` (bit 0)} combined with the state. The high nibble of the table byte becomes the next state. In read-shift mode, `rd_pulse` and data[7] choose different successors for the same state.
- R5: An action code whose bit 3 is 0 clears the data register.
- R6: An action code with bit 3 = 1 and bits 1:0 = 01 shifts the register left and puts action bit 2 into bit 0. Bits 1:0 = 00 leave the register unchanged.
- R7: An action code with bit 3 = 1 and bits 1:0 = 11 copies `wr_reg` into the data register. In write-load mode this happens at states 2 and 10. In write-shift mode those same states shift in a 0.
- R8: In write mode, a tick taken in a state whose bits 2:0 are 0 drives `head_bit` with bit 7 of the data register as it stands after that tick's action. `head_strobe` is raised in the clock cycle that follows.
- R9: `head_strobe` is high for exactly one clock cycle per written bit and is never high after a tick taken outside write mode.
- R10: In write mode, state 7 goes to 8 when data[7] is 1 and to 0 when it is 0. State 15 goes to 0 when data[7] is 1 and to 8 when it is 0. Every other state advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle sequencer step enable |
| wr_mode | input | 1 | 1 = write mode, 0 = read mode |
| ld_mode | input | 1 | 1 = load/sense mode, 0 = shift mode |
| rd_pulse | input | 1 | Read pulse from the bit-timing logic |
| wp_level | input | 1 | Write-protect level shifted in by the sense action |
| wr_reg | input | 8 | Host-written byte for parallel load |
| data_q | output | 8 | Data register |
| head_bit | output | 1 | Bit driven to the write head |
| head_strobe | output | 1 | One-cycle flag marking a written bit |

## Verification
Some behaviours are checked on every cycle. These are:
- the reset values;
- freezing while no tick arrives;
- the write-protect shift in read-load mode, including the return to state 0;
- the parallel load at state 2 in write-load mode;
- the single-cycle width of the write strobe, which may only follow a write-mode tick.

Other behaviours need a known state history, so only the directed scenarios can show them. These are:
- the exact table paths through read-shift mode under different read-pulse patterns;
- the clear reached through the data[7]=1 branch;
- the data[7]-dependent wrap at states 7 and 15 in write mode;
- the ticks on which head bits are emitted and their values.

// File: rtl/flux_seq_pkg.sv
// Shared constants and types for the floppy bit sequencer.
// Assumes an 8-bit data register and a 4-bit state; table bytes carry
// next state in the high nibble and action in the low nibble.
package flux_seq_pkg;
    localparam int DATA_W  = 8;
    localparam int STATE_W = 4;
    localparam int ACT_W   = 4;
    localparam int BYTE_W  = STATE_W + ACT_W;
    localparam int NSTATE  = 1 << STATE_W;
    localparam int COL_W   = BYTE_W * NSTATE;

    // Table address mode field, bit 3 down to bit 0.
    typedef struct packed {
        logic wr;
        logic ld;
        logic qa;
        logic rp;
    } seq_mode_t;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_SHL  = 2'd1,
        OP_SHR  = 2'd2,
        OP_LOAD = 2'd3
    } seq_op_t;

    // Read-shift columns, one byte per state, state 15 in the top byte.
    localparam logic [COL_W-1:0] COL_QA0_RP1 =
        128'hDD_FD_D8_D9_D9_CD_D8_D8_D8_D8_D8_D8_D8_D8_2D_18;
    localparam logic [COL_W-1:0] COL_QA0_RP0 =
        128'h4D_FD_08_D9_59_BD_29_98_88_78_68_58_48_38_2D_18;
    localparam logic [COL_W-1:0] COL_QA1_RP1 =
        128'hE0_F8_E8_D8_D8_D8_D8_D8_D8_D8_D8_D8_48_08_38_18;
    localparam logic [COL_W-1:0] COL_QA1_RP0 =
        128'hE0_F8_E8_A0_C8_B8_A8_98_88_78_68_58_48_28_38_18;
endpackage

// File: rtl/flux_seq_table.sv
// Sequencer table lookup, purely combinational.
// Write-mode and read-load entries are computed from their regular
// structure; read-shift entries come from four packed columns.
module flux_seq_table
    import flux_seq_pkg::*;
(
    input  seq_mode_t          mode,
    input  logic [STATE_W-1:0] state,
    output logic [STATE_W-1:0] next_state,
    output logic [ACT_W-1:0]   action
);
    localparam logic [STATE_W-1:0] S_LAST = STATE_W'(NSTATE - 1);
    localparam logic [STATE_W-1:0] S_MID  = STATE_W'(NSTATE / 2);
    localparam logic [STATE_W-1:0] S_PRE  = STATE_W'(NSTATE / 2 - 1);

    logic [COL_W-1:0]  column;
    logic [BYTE_W-1:0] entry;

    // Purpose: choose the read-shift column from the QA and read-pulse bits.
    always_comb begin
        unique case ({mode.qa, mode.rp})
            2'b00:   column = COL_QA0_RP0;
            2'b01:   column = COL_QA0_RP1;
            2'b10:   column = COL_QA1_RP0;
            default: column = COL_QA1_RP1;
        endcase
        entry = column[{state, 3'b000} +: BYTE_W];
    end

    // Purpose: produce next state and action for the current address.
    always_comb begin
        if (mode.wr) begin
            next_state = state + 1'b1;
            action     = 4'h8;
            if (state[2:0] == 3'd2)
                action = mode.ld ? 4'hB : 4'h9;
            if (state == S_PRE)
                next_state = mode.qa ? S_MID : '0;
            else if (state == S_LAST)
                next_state = mode.qa ? '0 : S_MID;
        end else if (mode.ld) begin
            next_state = '0;
            action     = 4'hA;
        end else begin
            next_state = entry[BYTE_W-1:ACT_W];
            action     = entry[ACT_W-1:0];
        end
    end
endmodule

// File: rtl/flux_seq_datareg.sv
// Data register with its action decoder.
// Assumes action bit 3 = 0 means clear; otherwise bits 1:0 choose keep,
// shift-left (bit 2 inserted), shift-right (write-protect inserted) or load.
module flux_seq_datareg
    import flux_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ACT_W-1:0]  action,
    input  logic              wp_level,
    input  logic [DATA_W-1:0] wr_reg,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] data_next
);
    seq_op_t op;

    // Purpose: compute the register value the current action produces.
    always_comb begin
        op = seq_op_t'(action[1:0]);
        if (!action[3]) begin
            data_next = '0;
        end else begin
            unique case (op)
                OP_SHL:  data_next = {data_q[DATA_W-2:0], action[2]};
                OP_SHR:  data_next = {wp_level, data_q[DATA_W-1:1]};
                OP_LOAD: data_next = wr_reg;
                default: data_next = data_q;
            endcase
        end
    end

    // Purpose: update the register on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (tick_en)
            data_q <= data_next;
    end
endmodule

// File: rtl/flux_sequencer.sv
// Floppy bit sequencer top: state register, table lookup, data register
// and head write output. Assumes tick_en is a single-cycle pulse that the
// bit-timing logic holds low while the motor is off.
module flux_sequencer
    import flux_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_mode,
    input  logic              ld_mode,
    input  logic              rd_pulse,
    input  logic              wp_level,
    input  logic [DATA_W-1:0] wr_reg,
    output logic [DATA_W-1:0] data_q,
    output logic              head_bit,
    output logic              head_strobe
);
    seq_mode_t          mode;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] next_state;
    logic [ACT_W-1:0]   action;
    logic [DATA_W-1:0]  data_next;
    logic               emit;

    // Purpose: assemble the table address mode field.
    always_comb begin
        mode.wr = wr_mode;
        mode.ld = ld_mode;
        mode.qa = data_q[DATA_W-1];
        mode.rp = rd_pulse;
    end

    flux_seq_table u_table (
        .mode       (mode),
        .state      (state_q),
        .next_state (next_state),
        .action     (action)
    );

    flux_seq_datareg u_dreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .action    (action),
        .wp_level  (wp_level),
        .wr_reg    (wr_reg),
        .data_q    (data_q),
        .data_next (data_next)
    );

    // Purpose: decide whether this tick writes a bit to the head.
    assign emit = tick_en && wr_mode && (state_q[2:0] == 3'd0);

    // Purpose: advance the sequence state on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (tick_en)
            state_q <= next_state;
    end

    // Purpose: register the head bit and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_bit    <= 1'b0;
            head_strobe <= 1'b0;
        end else begin
            head_strobe <= emit;
            if (emit)
                head_bit <= data_next[DATA_W-1];
        end
    end
endmodule

// File: rtl/flux_sequencer_chk.sv
// Property checker for flux_sequencer, attached by bind below.
// Observes ports plus the internal sequence state.
module flux_sequencer_chk
    import flux_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               wr_mode,
    input logic               ld_mode,
    input logic               wp_level,
    input logic [DATA_W-1:0]  wr_reg,
    input logic [DATA_W-1:0]  data_q,
    input logic               head_strobe,
    input logic [STATE_W-1:0] state_q
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && state_q == '0 && !head_strobe));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(data_q) && $stable(state_q) && !head_strobe));

    p_sense_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_mode && ld_mode) |=>
        (data_q == {$past(wp_level), $past(data_q[DATA_W-1:1])} && state_q == '0));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && wr_mode && ld_mode && state_q == 4'd2) |=> (data_q == $past(wr_reg)));

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        head_strobe |=> !head_strobe);

    p_strobe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        head_strobe |-> $past(tick_en && wr_mode));
endmodule

bind flux_sequencer flux_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .wr_mode     (wr_mode),
    .ld_mode     (ld_mode),
    .wp_level    (wp_level),
    .wr_reg      (wr_reg),
    .data_q      (data_q),
    .head_strobe (head_strobe),
    .state_q     (state_q)
);

// File: tb/flux_sequencer_test.sv
module flux_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_mode = 1'b0;
    logic       ld_mode = 1'b0;
    logic       rd_pulse = 1'b0;
    logic       wp_level = 1'b0;
    logic [7:0] wr_reg = 8'h00;
    logic [7:0] data_q;
    logic       head_bit;
    logic       head_strobe;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    flux_sequencer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_mode(wr_mode),
        .ld_mode(ld_mode), .rd_pulse(rd_pulse), .wp_level(wp_level),
        .wr_reg(wr_reg), .data_q(data_q), .head_bit(head_bit),
        .head_strobe(head_strobe)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_mode = 1'b0; ld_mode = 1'b0; rd_pulse = 1'b0; wp_level = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values, taken after running to a nonzero register.
    task automatic t_reset();
        do_reset();
        chk("R1 data", data_q, 8'h00);
        chk("R1 strobe", {7'd0, head_strobe}, 8'h00);
        chk("R1 head", {7'd0, head_bit}, 8'h00);
        ld_mode = 1'b1; wp_level = 1'b1;
        ticks(2);
        do_reset();
        chk("R1 data after use", data_q, 8'h00);
    endtask

    // R3: read-load shifts write-protect in at the top.
    task automatic t_sense();
        do_reset();
        ld_mode = 1'b1; wp_level = 1'b1;
        tick();
        chk("R3 first", data_q, 8'h80);
        ticks(7);
        chk("R3 full", data_q, 8'hFF);
        wp_level = 1'b0;
        ticks(3);
        chk("R3 zeros", data_q, 8'h1F);
        chk("R9 no strobe read", {7'd0, head_strobe}, 8'h00);
    endtask

    // R7, R8, R9, R10, R6: write-load then write-shift serialisation.
    task automatic t_write();
        logic exp_s;
        do_reset();
        wr_mode = 1'b1; ld_mode = 1'b1; wr_reg = 8'hA5;
        for (int k = 1; k <= 17; k++) begin
            tick();
            exp_s = (k == 1 || k == 9 || k == 17);
            chk("R8 strobe timing", {7'd0, head_strobe}, {7'd0, exp_s});
            if (k == 1) chk("R8 head bit first", {7'd0, head_bit}, 8'h00);
            if (k == 3) begin
                chk("R7 load", data_q, 8'hA5);
                ld_mode = 1'b0;
            end
            if (k == 9) begin
                chk("R10 state7 qa1 to 8, R8 head bit", {7'd0, head_bit}, 8'h01);
                @(negedge clk);
                chk("R9 strobe one cycle", {7'd0, head_strobe}, 8'h00);
            end
            if (k == 11) chk("R7 shift-left 0 at state 10", data_q, 8'h4A);
            if (k == 16) chk("R6 keep", data_q, 8'h4A);
            if (k == 17) chk("R10 state15 qa0 to 8, R8 head bit", {7'd0, head_bit}, 8'h00);
        end
    endtask

    // R4, R6: read-shift paths depend on the read pulse.
    task automatic t_read_shift();
        do_reset();
        ticks(2);
        chk("R6 shift-left 1", data_q, 8'h01);
        rd_pulse = 1'b1; tick();
        rd_pulse = 1'b0; tick();
        ticks(2);
        chk("R4 pulse branch path", data_q, 8'h03);
        ticks(8);
        chk("R4 no-pulse path", data_q, 8'h06);
    endtask

    // R2: no tick means no change; then the sequence resumes from state 2.
    task automatic t_hold();
        for (int i = 0; i < 20; i++) begin
            wr_mode = i[0]; ld_mode = i[1]; rd_pulse = i[2]; wp_level = 1'b1;
            wr_reg = 8'hFF;
            @(negedge clk);
            if (head_strobe) begin
                checks++; failures++;
                $display("FAIL R2 strobe got=1 expected=0");
            end
        end
        chk("R2 data held", data_q, 8'h06);
        wr_mode = 1'b0; ld_mode = 1'b0; rd_pulse = 1'b0;
        ticks(8);
        chk("R2 state held", data_q, 8'h0C);
    endtask

    // R5: clear reached through the data[7]=1 read-shift branch.
    task automatic t_clear();
        do_reset();
        ld_mode = 1'b1; wp_level = 1'b1;
        tick();
        ld_mode = 1'b0;
        ticks(11);
        chk("R5 before clear", data_q, 8'h80);
        tick();
        chk("R5 clear", data_q, 8'h00);
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog got=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_sense();
        t_write();
        t_read_shift();
        t_hold();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule